// File: doc/BRIEF.md
# Read Capture Delay Calibration Controller

This controller runs once after power-up, before any user traffic, to tune two programmable input delay lines in a source-synchronous read path: one on the returned echo clock and one on the returned read data. It does not contain the delay lines or the memory. It drives increment and clear pulses for each delay line, issues write and read requests toward the memory, and compares the four-word burst captured by the read path against the pattern it last wrote.

Calibration has three stages. Stage one writes a burst with a constant pattern and reads it back repeatedly. It first sweeps the clock delay to measure the hold side of the eye and then sweeps the data delay to measure the setup side. After that it offsets one of the two delays so that the clock sits in the middle of the eye. Stage two writes a burst with transitions and moves both delays together to find a window against the system clock that is wide enough. A window that is too narrow is dropped and the search continues toward the next clock edge. Stage three issues several spaced reads and counts how many cycles the read command has to be delayed to line up with the returned data. That count then sets the tap of a shift register that turns later read commands into a data-valid strobe.

Top module: `rdcal_ctrl`

## Requirements
- R1: After reset, and for as long as `dly_rdy` is low, the block issues no write or read request and no tap increment or clear pulse. `cal_done`, `cal_err` and `rd_valid` stay low.
- R2: The first request after `dly_rdy` rises is a one-cycle write. Its `wr_data` burst is laid out as {rise0, fall0, rise1, fall1}, with rise0 in the top byte, and holds FF,00,FF,00. `req_wr` and `req_rd` are never high in the same cycle.
- R3: Stage one steps the clock tap up from 0 after each matching read. The last matching tap is the hold width H. Both taps are then cleared and the data tap is swept the same way to give the setup width S. After a second clear, the clock tap is raised by floor((H-S)/2) when H>=S; otherwise the data tap is raised by floor((S-H)/2).
- R4: Stage two begins with a write burst of FF,00,55,AA in the layout of R2.
- R5: In stage two, both taps rise together by one after every read. A run of matching positions shorter than MIN_WIN is discarded and the search goes on. MIN_WIN is 15 when FAST_CLK=1; otherwise it is floor(CLK_PS/2/TAP_PS). The first run that is long enough ends the stage. Each tap then ends at its stage-one value plus the run's start offset plus floor(run length/2).
- R6: No increment is issued to a tap that is already at NTAPS-1, and a tap counter ignores an increment at that value. A sweep that reaches the maximum tap while reads still match ends there.
- R7: Stage three issues NREAD reads. Each read is issued only after the data of the previous read has returned. The latency is the number of cycles from the request cycle to the cycle in which the matching burst appears, and it must be the same for every read.
- R8: After a successful calibration, a `usr_rd` pulse in cycle c gives a `rd_valid` pulse in exactly cycle c+latency. `rd_valid` is never high before `cal_done`, and never high while `cal_err` is set.
- R9: `cal_done` and `cal_err` both assert in any of these cases: the read at tap 0 in stage one fails; stage two hits a saturated tap without finding a long enough window; a stage-three read sees no match within MAX_LAT cycles; or the stage-three latencies differ.
- R10: Once `cal_done` and `cal_err` are set, they hold their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dly_rdy | input | 1 | Delay-line control ready; calibration waits for it |
| cap_data | input | 32 | Captured read burst {rise0, fall0, rise1, fall1} |
| usr_rd | input | 1 | Read command from the main controller after calibration |
| req_wr | output | 1 | One-cycle write request |
| req_rd | output | 1 | One-cycle read request |
| wr_data | output | 32 | Burst to write, same layout as cap_data |
| cq_inc | output | 1 | Step the clock delay up by one tap |
| cq_clr | output | 1 | Return the clock delay to tap 0 |
| q_inc | output | 1 | Step the data delay up by one tap |
| q_clr | output | 1 | Return the data delay to tap 0 |
| rd_valid | output | 1 | Read-data-valid strobe, `usr_rd` delayed by the measured latency |
| cal_done | output | 1 | Calibration finished, whether it succeeded or not |
| cal_err | output | 1 | Calibration failed |

## Verification
The bench builds the block with NTAPS=64, MAX_LAT=16, NREAD=3 and FAST_CLK=1, so MIN_WIN is 15. With these values, a modelled system-clock window 8 taps wide has to be discarded before a 21-tap window is accepted. An eye wider than the whole range pushes the stage-one sweeps to tap 63, where the saturation rule applies. The short MAX_LAT keeps each failing read cheap, so runs where the eye is missing or only the narrow window exists still finish quickly. These runs reach the stage-one and stage-two error exits. Two different model latencies check that the measured count drives the valid strobe.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;

    localparam int BYTE_W  = 8;
    localparam int BURST_W = 4 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WR, ST_RD, ST_WT, ST_RSTT, ST_SEEK, ST_DONE, ST_ERR
    } st_t;

    typedef enum logic [1:0] {
        PH_HOLD, PH_SETUP, PH_CLK, PH_LAT
    } ph_t;

    typedef struct packed {
        logic [BYTE_W-1:0] rise0;
        logic [BYTE_W-1:0] fall0;
        logic [BYTE_W-1:0] rise1;
        logic [BYTE_W-1:0] fall1;
    } burst_t;

    // Constant pattern while eye edges are measured, transitioning pattern afterwards
    function automatic burst_t pattern(ph_t ph);
        burst_t b;
        b.rise0 = '1;
        b.fall0 = '0;
        if (ph == PH_HOLD || ph == PH_SETUP) begin
            b.rise1 = '1;
            b.fall1 = '0;
        end else begin
            b.rise1 = {(BYTE_W/2){2'b01}};
            b.fall1 = {(BYTE_W/2){2'b10}};
        end
        return b;
    endfunction

    function automatic logic [15:0] clamp_add(logic [15:0] a, logic [15:0] b, logic [15:0] lim);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s > {1'b0, lim}) ? lim : s[15:0];
    endfunction

endpackage

// File: rtl/rdcal_tap.sv
module rdcal_tap #(
    parameter int NTAPS = 64,
    localparam int TW = $clog2(NTAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          clr,
    output logic [TW-1:0] tap,
    output logic          sat
);
    logic [TW-1:0] tap_q;

    assign sat = (tap_q == TW'(NTAPS - 1));
    assign tap = tap_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            tap_q <= '0;
        else if (inc && !sat)
            tap_q <= tap_q + TW'(1);
    end

    AST_TAP_CEIL: assert property (@(posedge clk) disable iff (rst)
        (sat && inc && !clr) |=> sat) else $error("tap left ceiling"); // R6

endmodule

// File: rtl/rdcal_vld.sv
module rdcal_vld #(
    parameter int MAX_LAT = 16,
    localparam int LW = $clog2(MAX_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [LW-1:0] lat,
    input  logic          cmd,
    output logic          vld
);
    logic [MAX_LAT-1:0] sr;

    generate
        if (MAX_LAT == 1) begin : g_one
            always_ff @(posedge clk) sr <= rst ? '0 : cmd;
        end else begin : g_many
            always_ff @(posedge clk) sr <= rst ? '0 : {sr[MAX_LAT-2:0], cmd};
        end
    endgenerate

    assign vld = en && (lat != '0) && sr[lat - LW'(1)];

    AST_VLD_LAT_NZ: assert property (@(posedge clk) disable iff (rst)
        en |-> (lat != '0)) else $error("strobe enabled with zero latency"); // R7

endmodule

// File: rtl/rdcal_ctrl.sv
module rdcal_ctrl
    import rdcal_pkg::*;
#(
    parameter int NTAPS    = 64,
    parameter int MAX_LAT  = 16,
    parameter int NREAD    = 3,
    parameter bit FAST_CLK = 1'b1,
    parameter int CLK_PS   = 3333,
    parameter int TAP_PS   = 75
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dly_rdy,
    input  logic [BURST_W-1:0] cap_data,
    input  logic               usr_rd,
    output logic               req_wr,
    output logic               req_rd,
    output logic [BURST_W-1:0] wr_data,
    output logic               cq_inc,
    output logic               cq_clr,
    output logic               q_inc,
    output logic               q_clr,
    output logic               rd_valid,
    output logic               cal_done,
    output logic               cal_err
);
    localparam int TW      = $clog2(NTAPS);
    localparam int WW      = TW + 1;
    localparam int LW      = $clog2(MAX_LAT + 1);
    localparam int NRW     = $clog2(NREAD + 1);
    localparam int TMAX    = NTAPS - 1;
    localparam int MIN_WIN = FAST_CLK ? 15 : (CLK_PS / 2) / TAP_PS;

    st_t           st;
    ph_t           ph;
    logic [LW-1:0] cnt, lat;
    logic [NRW-1:0] nrd;
    logic [TW-1:0] hold_w, cq_base, q_base, cq_tgt, q_tgt, win_start;
    logic [WW-1:0] win_len;
    logic [TW-1:0] cq_tap, q_tap;
    logic          cq_sat, q_sat;

    burst_t        pat;
    logic          hit, tmo, any_sat;
    logic [TW-1:0] koff, st_use, setup_v, fin_start;
    logic [WW-1:0] len_nx, fin_len;

    assign pat      = pattern(ph);
    assign hit      = (st == ST_WT) && (cap_data == pat);
    assign tmo      = (st == ST_WT) && !hit && (cnt >= LW'(MAX_LAT));
    assign any_sat  = cq_sat || q_sat;
    assign koff     = q_tap - q_base;
    assign len_nx   = win_len + WW'(1);
    assign st_use   = (win_len == '0) ? koff : win_start;
    assign fin_start = hit ? st_use : win_start;
    assign fin_len  = hit ? len_nx : win_len;
    assign setup_v  = hit ? q_tap : q_tap - TW'(1);

    assign req_wr   = (st == ST_WR);
    assign req_rd   = (st == ST_RD);
    assign wr_data  = pat;
    assign cq_clr   = (st == ST_RSTT);
    assign q_clr    = (st == ST_RSTT);
    assign cal_done = (st == ST_DONE) || (st == ST_ERR);
    assign cal_err  = (st == ST_ERR);

    always_comb begin
        cq_inc = 1'b0;
        q_inc  = 1'b0;
        case (st)
            ST_WT: begin
                case (ph)
                    PH_HOLD:  cq_inc = hit && !cq_sat;
                    PH_SETUP: q_inc  = hit && !q_sat;
                    PH_CLK: begin
                        cq_inc = !any_sat && (hit || (tmo && win_len < WW'(MIN_WIN)));
                        q_inc  = cq_inc;
                    end
                    default: ;
                endcase
            end
            ST_SEEK: begin
                cq_inc = (cq_tap != cq_tgt);
                q_inc  = (q_tap != q_tgt);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;  ph <= PH_HOLD;
            cnt <= '0;  lat <= '0;  nrd <= '0;
            hold_w <= '0;  cq_base <= '0;  q_base <= '0;
            cq_tgt <= '0;  q_tgt <= '0;  win_start <= '0;  win_len <= '0;
        end else begin
            case (st)
                ST_IDLE: if (dly_rdy) begin ph <= PH_HOLD; st <= ST_WR; end
                ST_WR:   st <= ST_RD;
                ST_RD:   begin cnt <= LW'(1); st <= ST_WT; end
                ST_WT: begin
                    cnt <= cnt + LW'(1);
                    case (ph)
                        PH_HOLD: begin
                            if (hit) begin
                                if (cq_sat) begin hold_w <= cq_tap; st <= ST_RSTT; end
                                else st <= ST_RD;
                            end else if (tmo) begin
                                if (cq_tap == '0) st <= ST_ERR;
                                else begin hold_w <= cq_tap - TW'(1); st <= ST_RSTT; end
                            end
                        end
                        PH_SETUP: begin
                            if ((hit && q_sat) || (tmo && q_tap != '0)) begin
                                if (hold_w >= setup_v) begin
                                    cq_tgt <= (hold_w - setup_v) >> 1;  q_tgt <= '0;
                                end else begin
                                    q_tgt <= (setup_v - hold_w) >> 1;  cq_tgt <= '0;
                                end
                                st <= ST_RSTT;
                            end else if (hit) st <= ST_RD;
                            else if (tmo) st <= ST_ERR;
                        end
                        PH_CLK: begin
                            if (hit) begin
                                if (win_len == '0) win_start <= koff;
                                win_len <= len_nx;
                            end else if (tmo && win_len < WW'(MIN_WIN))
                                win_len <= '0;
                            if ((hit && any_sat) || (tmo && win_len >= WW'(MIN_WIN))) begin
                                if (fin_len >= WW'(MIN_WIN)) begin
                                    cq_tgt <= TW'(clamp_add(16'(cq_base),
                                              16'(fin_start) + 16'(fin_len >> 1), 16'(TMAX)));
                                    q_tgt  <= TW'(clamp_add(16'(q_base),
                                              16'(fin_start) + 16'(fin_len >> 1), 16'(TMAX)));
                                    st <= ST_RSTT;
                                end else st <= ST_ERR;
                            end else if (hit) st <= ST_RD;
                            else if (tmo) st <= any_sat ? ST_ERR : ST_RD;
                        end
                        default: begin
                            if (hit) begin
                                if (nrd != '0 && cnt != lat) st <= ST_ERR;
                                else begin
                                    if (nrd == '0) lat <= cnt;
                                    if (nrd == NRW'(NREAD - 1)) st <= ST_DONE;
                                    else begin nrd <= nrd + NRW'(1); st <= ST_RD; end
                                end
                            end else if (tmo) st <= ST_ERR;
                        end
                    endcase
                end
                ST_RSTT: begin
                    if (ph == PH_HOLD) begin ph <= PH_SETUP; st <= ST_RD; end
                    else st <= ST_SEEK;
                end
                ST_SEEK: begin
                    if (cq_tap == cq_tgt && q_tap == q_tgt) begin
                        if (ph == PH_SETUP) begin
                            cq_base <= cq_tgt;  q_base <= q_tgt;
                            win_len <= '0;  ph <= PH_CLK;  st <= ST_WR;
                        end else begin
                            nrd <= '0;  ph <= PH_LAT;  st <= ST_RD;
                        end
                    end
                end
                default: st <= st;
            endcase
        end
    end

    rdcal_tap #(.NTAPS(NTAPS)) u_cq_tap (
        .clk(clk), .rst(rst), .inc(cq_inc), .clr(cq_clr), .tap(cq_tap), .sat(cq_sat));

    rdcal_tap #(.NTAPS(NTAPS)) u_q_tap (
        .clk(clk), .rst(rst), .inc(q_inc), .clr(q_clr), .tap(q_tap), .sat(q_sat));

    rdcal_vld #(.MAX_LAT(MAX_LAT)) u_vld (
        .clk(clk), .rst(rst), .en(st == ST_DONE), .lat(lat), .cmd(usr_rd), .vld(rd_valid));

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(req_wr && req_rd)) else $error("write and read together"); // R2
    AST_NO_INC_AT_MAX: assert property (@(posedge clk) disable iff (rst)
        !(cq_inc && cq_sat) && !(q_inc && q_sat)) else $error("increment at top tap"); // R6
    AST_NO_VLD_EARLY: assert property (@(posedge clk) disable iff (rst)
        !(cal_done && !cal_err) |-> !rd_valid) else $error("strobe before success"); // R8
    AST_QUIET_BEFORE_RDY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !(cq_inc || q_inc || cq_clr || q_clr)) else $error("tap activity idle"); // R1
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> cal_done) else $error("done dropped"); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cal_err |=> cal_err) else $error("error dropped"); // R10

endmodule

// File: tb/rdcal_ctrl_test.sv
module rdcal_ctrl_test;
    import rdcal_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 64;
    localparam logic [31:0] P1 = 32'hFF00FF00;
    localparam logic [31:0] P2 = 32'hFF0055AA;

    logic clk = 1'b0;
    logic rst = 1'b1, dly_rdy = 1'b0, usr_rd = 1'b0;
    logic [31:0] cap_data, wr_data;
    logic req_wr, req_rd, cq_inc, cq_clr, q_inc, q_clr, rd_valid, cal_done, cal_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdcal_ctrl #(.NTAPS(NT), .MAX_LAT(16), .NREAD(3), .FAST_CLK(1'b1),
                 .CLK_PS(3333), .TAP_PS(75)) uut (
        .clk(clk), .rst(rst), .dly_rdy(dly_rdy), .cap_data(cap_data), .usr_rd(usr_rd),
        .req_wr(req_wr), .req_rd(req_rd), .wr_data(wr_data), .cq_inc(cq_inc),
        .cq_clr(cq_clr), .q_inc(q_inc), .q_clr(q_clr), .rd_valid(rd_valid),
        .cal_done(cal_done), .cal_err(cal_err));

    // ---- memory and delay-line model ----
    int hold_m = 9, setup_m = 3, lat_m = 5;
    bit dead = 1'b0, win2_en = 1'b1;
    int mcq, mq, inc_at_max, cyc = 0;
    logic [31:0] mem;
    logic [15:0] rdpipe;
    logic eye_ok, clk_ok, good;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            mcq <= 0; mq <= 0; rdpipe <= '0; mem <= '0; inc_at_max <= 0;
        end else begin
            if (cq_clr) mcq <= 0;
            else if (cq_inc) begin
                if (mcq == NT-1) inc_at_max <= inc_at_max + 1; else mcq <= mcq + 1;
            end
            if (q_clr) mq <= 0;
            else if (q_inc) begin
                if (mq == NT-1) inc_at_max <= inc_at_max + 1; else mq <= mq + 1;
            end
            if (req_wr) mem <= wr_data;
            rdpipe <= {rdpipe[14:0], req_rd};
        end
    end

    assign eye_ok  = !dead && (mcq - mq <= hold_m) && (mq - mcq <= setup_m);
    assign clk_ok  = (mq >= 3 && mq <= 10) || (win2_en && mq >= 20 && mq <= 40);
    assign good    = eye_ok && (mem == P1 || clk_ok);
    assign cap_data = rdpipe[lat_m-1] ? (good ? mem : ~mem) : 32'h0;

    // ---- scoreboard ----
    int n_chk = 0, n_bad = 0, quiet_viol = 0;
    bit seen_req = 1'b0, finished = 1'b0;
    logic [31:0] exp_wr[$];
    int exp_vld[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!dly_rdy && (req_wr || req_rd || cq_inc || q_inc || cq_clr || q_clr))
                quiet_viol++;
            if ((req_wr || req_rd) && !seen_req) begin
                seen_req = 1'b1;
                chk(req_wr && !req_rd, "R2 first request is write", req_wr, 1);
            end
            if (req_wr) begin
                if (exp_wr.size() == 0) chk(0, "R4 unexpected write", wr_data, 0);
                else begin
                    automatic logic [31:0] e = exp_wr.pop_front();
                    chk(wr_data == e, (e == P1) ? "R2 stage-one burst" : "R4 stage-two burst",
                        wr_data, e);
                end
            end
            if (rd_valid) begin
                if (exp_vld.size() == 0) chk(0, "R8 unexpected rd_valid", cyc, 0);
                else begin
                    automatic int e = exp_vld.pop_front();
                    chk(cyc == e, "R8 rd_valid cycle (R7 latency)", cyc, e);
                end
            end
        end
    end

    task automatic run(input int hm, input int sm, input bit dd, input bit w2, input int lm,
                       input bit exp_err, input bit two_writes, input int ecq, input int eq);
        int n;
        hold_m = hm; setup_m = sm; dead = dd; win2_en = w2; lat_m = lm;
        exp_wr.delete(); exp_vld.delete();
        rst = 1'b1; dly_rdy = 1'b0; usr_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_wr.push_back(P1);
        if (two_writes) exp_wr.push_back(P2);
        quiet_viol = 0;
        repeat (30) @(negedge clk);
        chk(quiet_viol == 0, "R1 no activity before ready", quiet_viol, 0);
        chk(!cal_done && !cal_err && !rd_valid, "R1 flags low", {cal_done, cal_err, rd_valid}, 0);
        seen_req = 1'b0;
        dly_rdy = 1'b1;
        repeat (6) @(negedge clk);
        usr_rd = 1'b1; @(negedge clk); usr_rd = 1'b0;   // R8: must not produce rd_valid
        n = 0;
        while (!cal_done && n < 30000) begin @(negedge clk); n++; end
        chk(n < 30000, "R9 calibration finished", n, 0);
        chk(cal_err == exp_err, "R9 error flag", cal_err, exp_err);
        chk(exp_wr.size() == 0, "R4 all pattern writes issued", exp_wr.size(), 0);
        chk(inc_at_max == 0, "R6 no increment at top tap", inc_at_max, 0);
        if (!exp_err) begin
            chk(mcq == ecq, "R3 R5 final clock tap", mcq, ecq);
            chk(mq == eq, "R3 R5 final data tap", mq, eq);
            usr_rd = 1'b1; exp_vld.push_back(cyc + lm); @(negedge clk);
            exp_vld.push_back(cyc + lm); @(negedge clk);
            usr_rd = 1'b0;
            repeat (4) @(negedge clk);
            usr_rd = 1'b1; exp_vld.push_back(cyc + lm); @(negedge clk);
            usr_rd = 1'b0;
        end else begin
            usr_rd = 1'b1; @(negedge clk); usr_rd = 1'b0;   // R8: no strobe after error
        end
        repeat (25) @(negedge clk);
        chk(exp_vld.size() == 0, "R7 R8 all strobes seen", exp_vld.size(), 0);
        chk(cal_done && cal_err == exp_err, "R10 flags held", {cal_done, cal_err}, {1'b1, exp_err});
    endtask

    initial begin
        // nominal: hold 9, setup 3 -> clock +3; narrow window 3..10 dropped, 20..40 kept
        run(9, 3, 1'b0, 1'b1, 5, 1'b0, 1'b1, 33, 30);
        // eye wider than range: sweeps saturate at 63, no centring offset
        run(100, 100, 1'b0, 1'b1, 7, 1'b0, 1'b1, 30, 30);
        // no eye at all: stage-one error
        run(-1, -1, 1'b1, 1'b1, 5, 1'b1, 1'b0, 0, 0);
        // only the narrow system-clock window: stage-two error
        run(9, 3, 1'b0, 1'b0, 5, 1'b1, 1'b1, 0, 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            chk(0, "watchdog expired", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule